// File: doc/BRIEF.md
# Single-Action Panel Switch Sequencer

This block turns one front-panel switch action, such as a halt request, into one fixed pass through a short series of control phases. It runs from a 25 MHz system clock. A free-running divider produces two alternating timing strobes, called early and late, that fire on alternate divide-by-4 ticks. It also produces an inverted divide-by-16 level for slower panel display logic. A state machine steps on the early strobe.

A switch touch is first delayed for a programmable number of cycles. A one-shot pulse follows. When the pulse ends, the sequencer arms and waits for an early strobe, then enters phase A. Entering phase A opens an active-low hold window, which leaves time for an external address increment. Phase A lasts one strobe period. The sequencer then waits until the hold window has closed, marks itself ready, and enters phase B on the next early strobe. During phase B the late strobe drives an active-low bus-request output.

Entering phase B sets a lockout flag. This flag keeps a switch that is still held from starting a second pass. Separately, a small bank of request flags records any address-clear, address/data or control-switch event, together with master reset, until each flag is acknowledged.

States, in order:
- IDLE: no sequence is running.
- DELAY: the touch delay is counting.
- PULSE: the one-shot is high.
- ARMED: waiting for an early strobe.
- PHASE_A: the first control phase.
- HOLD_WAIT: phase A has ended and the hold window is still open.
- READY: waiting for an early strobe.
- PHASE_B: the second control phase.

Transitions:
- start: IDLE to DELAY.
- delay_done: DELAY to PULSE.
- pulse_done: PULSE to ARMED.
- arm_fire: ARMED to PHASE_A.
- a_done: PHASE_A to HOLD_WAIT.
- hold_done: HOLD_WAIT to READY.
- b_fire: READY to PHASE_B.
- b_done: PHASE_B to IDLE.

Top module: `psw_switch_seq`

## Requirements
- R1: Count the first rising clock edge after reset release as edge 1. The early strobe `ph0_o` is high for one cycle after edges 3, 11, 19 and so on (edge count mod 8 = 3). The late strobe `ph1_o` is high for one cycle after edges 7, 15, 23 and so on (edge count mod 8 = 7). The two strobes are never high together.
- R2: `slow_clk_n_o` is high when bit 3 of the edge count mod 16 is 0 and low when that bit is 1. It is high from reset.
- R3: In IDLE, with `halt_sw_i` high and `lockout_o` low, the start transition occurs. DELAY then lasts exactly DELAY_CYC cycles, followed by `oneshot_o` high for exactly PULSE_CYC cycles.
- R4: `armed_o` is high from the end of the pulse until the first cycle in which `ph0_o` is high. The next cycle enters PHASE_A, where `phase_a_o` is high. At most one of the oneshot, armed, phase A, ready and phase B outputs is high at any time.
- R5: `hold_n_o` goes low in the first PHASE_A cycle and stays low for exactly HOLD_CYC cycles.
- R6: PHASE_A ends after the next `ph0_o` cycle. HOLD_WAIT then lasts until `hold_n_o` is high, after which `ready_o` is high until a `ph0_o` cycle. The following cycle is the first PHASE_B cycle.
- R7: PHASE_B ends after the next `ph0_o` cycle and returns to IDLE. `bus_req_n_o` is low exactly in the PHASE_B cycles in which `ph1_o` is high, which is one cycle per pass.
- R8: `lockout_o` is set on entering PHASE_B and cleared in the cycle after `halt_sw_i` is sampled low. A switch level or touch seen while a sequence is running, or while `lockout_o` is high, starts nothing.
- R9: `stat_o` is set by `stat_set_i` and cleared on entering PHASE_A. The clear wins over a set in the same cycle.
- R10: Each bit of `req_pend_o` is set to 1 in the cycle after any of `addr_clr_i`, `sw_touch_i` or `ctl_touch_i` is high. Otherwise the bit is cleared by the matching bit of `req_ack_i`. A set wins over an acknowledge.
- R11: While `rst_n` is low, the block is in IDLE with the divider at 0. All phase outputs are low, `hold_n_o` and `bus_req_n_o` are high, `lockout_o` and `stat_o` are low, and every `req_pend_o` bit is 1.
- R12: `phase_a_n_o` and `phase_b_n_o` are always the inverse of `phase_a_o` and `phase_b_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz system clock |
| rst_n | input | 1 | Active-low master reset, asynchronous |
| halt_sw_i | input | 1 | Debounced switch level, high while touched |
| stat_set_i | input | 1 | Sets the status flag |
| addr_clr_i | input | 1 | Address-clear event |
| sw_touch_i | input | 1 | Address or data switch touched |
| ctl_touch_i | input | 1 | Run, register-read or register-write switch touched |
| req_ack_i | input | REQ_N | Per-flag acknowledge |
| ph0_o | output | 1 | Early timing strobe |
| ph1_o | output | 1 | Late timing strobe |
| slow_clk_n_o | output | 1 | Inverted divide-by-16 level |
| oneshot_o | output | 1 | One-shot pulse |
| armed_o | output | 1 | Armed, waiting for the early strobe |
| phase_a_o | output | 1 | Phase A active |
| phase_a_n_o | output | 1 | Phase A complement |
| hold_n_o | output | 1 | Active-low hold window |
| ready_o | output | 1 | Ready for phase B |
| phase_b_o | output | 1 | Phase B active |
| phase_b_n_o | output | 1 | Phase B complement |
| bus_req_n_o | output | 1 | Active-low bus request, late strobe within phase B |
| lockout_o | output | 1 | Re-entry lockout |
| stat_o | output | 1 | Status flag |
| req_pend_o | output | REQ_N | Pending request flags |

## Verification
The bench builds the sequencer with DELAY_CYC = 40, PULSE_CYC = 5, HOLD_CYC = 30 and two request flags, instead of the tens of thousands of cycles used at 25 MHz. With these values a complete pass takes about a hundred cycles, so several passes fit in one run. Those passes cover:
- a switch held through the whole pass;
- a short touch;
- a second touch in the middle of a pass;
- a reset in the middle of a pass.

HOLD_CYC is longer than one strobe period, so the HOLD_WAIT state is actually occupied and the path from the hold window's end to READY is exercised.

// File: rtl/psw_pkg.sv
package psw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_DELAY     = 3'd1,
        ST_PULSE     = 3'd2,
        ST_ARMED     = 3'd3,
        ST_PHASE_A   = 3'd4,
        ST_HOLD_WAIT = 3'd5,
        ST_READY     = 3'd6,
        ST_PHASE_B   = 3'd7
    } psw_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/psw_phase_gen.sv
module psw_phase_gen #(
    parameter int DIV_W = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic ph0_o,
    output logic ph1_o,
    output logic slow_n_o
);
    localparam int SLOW_BIT = DIV_W - 1;

    logic [DIV_W-1:0] cnt_q;
    logic             tgl_q;
    logic             tick;

    // divide-by-4 tick from the two low bits
    assign tick = &cnt_q[1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
            if (tick) begin
                tgl_q <= ~tgl_q;
            end
        end
    end

    assign ph0_o    = tick & ~tgl_q;
    assign ph1_o    = tick & tgl_q;
    assign slow_n_o = ~cnt_q[SLOW_BIT];

endmodule

// File: rtl/psw_hold_timer.sv
module psw_hold_timer #(
    parameter int HOLD_CYC = 256
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic hold_n_o
);
    localparam int             HW        = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0]  HOLD_LOAD = HW'(HOLD_CYC);

    logic [HW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= HOLD_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign hold_n_o = (cnt_q == '0);

endmodule

// File: rtl/psw_req_latch.sv
module psw_req_latch #(
    parameter int REQ_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_i,
    input  logic [REQ_N-1:0] ack_i,
    output logic [REQ_N-1:0] pend_o
);
    for (genvar g = 0; g < REQ_N; g++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_o[g] <= 1'b1;
            end else if (set_i) begin
                pend_o[g] <= 1'b1;
            end else if (ack_i[g]) begin
                pend_o[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/psw_switch_seq.sv
module psw_switch_seq
    import psw_pkg::*;
#(
    parameter int DELAY_CYC = 47500,
    parameter int PULSE_CYC = 85,
    parameter int HOLD_CYC  = 256,
    parameter int REQ_N     = 2,
    parameter int DIV_W     = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_sw_i,
    input  logic             stat_set_i,
    input  logic             addr_clr_i,
    input  logic             sw_touch_i,
    input  logic             ctl_touch_i,
    input  logic [REQ_N-1:0] req_ack_i,
    output logic             ph0_o,
    output logic             ph1_o,
    output logic             slow_clk_n_o,
    output logic             oneshot_o,
    output logic             armed_o,
    output logic             phase_a_o,
    output logic             phase_a_n_o,
    output logic             hold_n_o,
    output logic             ready_o,
    output logic             phase_b_o,
    output logic             phase_b_n_o,
    output logic             bus_req_n_o,
    output logic             lockout_o,
    output logic             stat_o,
    output logic [REQ_N-1:0] req_pend_o
);
    localparam int              SEQ_W     = $clog2(max_u(DELAY_CYC, PULSE_CYC) + 1);
    localparam logic [SEQ_W-1:0] DLY_LOAD = SEQ_W'(DELAY_CYC - 1);
    localparam logic [SEQ_W-1:0] PUL_LOAD = SEQ_W'(PULSE_CYC - 1);

    psw_state_e       state_q, state_d;
    logic [SEQ_W-1:0] seq_cnt_q;
    logic             seq_zero;
    logic             start;
    logic             enter_a;
    logic             enter_b;
    logic             ph0, ph1;
    logic             hold_n;
    logic             lock_q;
    logic             stat_q;

    // ---------------- divider and strobes ----------------
    psw_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .ph0_o    (ph0),
        .ph1_o    (ph1),
        .slow_n_o (slow_clk_n_o)
    );

    // ---------------- hold window ----------------
    psw_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (enter_a),
        .hold_n_o (hold_n)
    );

    // ---------------- request flags ----------------
    psw_req_latch #(.REQ_N(REQ_N)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (addr_clr_i | sw_touch_i | ctl_touch_i),
        .ack_i  (req_ack_i),
        .pend_o (req_pend_o)
    );

    // ---------------- transition terms ----------------
    assign seq_zero = (seq_cnt_q == '0);
    assign start    = (state_q == ST_IDLE) && halt_sw_i && !lock_q;
    assign enter_a  = (state_q == ST_ARMED) && ph0;
    assign enter_b  = (state_q == ST_READY) && ph0;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start)    state_d = ST_DELAY;      // start
            ST_DELAY:     if (seq_zero) state_d = ST_PULSE;      // delay_done
            ST_PULSE:     if (seq_zero) state_d = ST_ARMED;      // pulse_done
            ST_ARMED:     if (ph0)      state_d = ST_PHASE_A;    // arm_fire
            ST_PHASE_A:   if (ph0)      state_d = ST_HOLD_WAIT;  // a_done
            ST_HOLD_WAIT: if (hold_n)   state_d = ST_READY;      // hold_done
            ST_READY:     if (ph0)      state_d = ST_PHASE_B;    // b_fire
            ST_PHASE_B:   if (ph0)      state_d = ST_IDLE;       // b_done
            default:                    state_d = ST_IDLE;
        endcase
    end

    // ---------------- delay / pulse counter ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_cnt_q <= '0;
        end else if (start) begin
            seq_cnt_q <= DLY_LOAD;
        end else if (state_q == ST_DELAY) begin
            seq_cnt_q <= seq_zero ? PUL_LOAD : seq_cnt_q - 1'b1;
        end else if (state_q == ST_PULSE && !seq_zero) begin
            seq_cnt_q <= seq_cnt_q - 1'b1;
        end
    end

    // ---------------- lockout and status flags ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
        end else if (enter_b) begin
            lock_q <= 1'b1;
        end else if (!halt_sw_i) begin
            lock_q <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= 1'b0;
        end else if (enter_a) begin
            stat_q <= 1'b0;
        end else if (stat_set_i) begin
            stat_q <= 1'b1;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        oneshot_o = 1'b0;
        armed_o   = 1'b0;
        phase_a_o = 1'b0;
        ready_o   = 1'b0;
        phase_b_o = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DELAY, ST_HOLD_WAIT: ;
            ST_PULSE:   oneshot_o = 1'b1;
            ST_ARMED:   armed_o   = 1'b1;
            ST_PHASE_A: phase_a_o = 1'b1;
            ST_READY:   ready_o   = 1'b1;
            ST_PHASE_B: phase_b_o = 1'b1;
            default: ;
        endcase
        phase_a_n_o = ~phase_a_o;
        phase_b_n_o = ~phase_b_o;
        bus_req_n_o = ~(phase_b_o & ph1);
        hold_n_o    = hold_n;
        ph0_o       = ph0;
        ph1_o       = ph1;
        lockout_o   = lock_q;
        stat_o      = stat_q;
    end

endmodule

// File: rtl/psw_seq_checks.sv
module psw_seq_checks #(
    parameter int REQ_N = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             addr_clr_i,
    input logic             sw_touch_i,
    input logic             ctl_touch_i,
    input logic             ph0_o,
    input logic             ph1_o,
    input logic             oneshot_o,
    input logic             armed_o,
    input logic             phase_a_o,
    input logic             hold_n_o,
    input logic             ready_o,
    input logic             phase_b_o,
    input logic             bus_req_n_o,
    input logic             lockout_o,
    input logic             stat_o,
    input logic [REQ_N-1:0] req_pend_o
);
    assert_strobe_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (ph0_o || ph1_o) |=> !ph0_o && !ph1_o);

    assert_phase_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({oneshot_o, armed_o, phase_a_o, ready_o, phase_b_o}));

    assert_enter_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a_o) |-> $past(armed_o) && $past(ph0_o));

    assert_hold_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a_o) |-> !hold_n_o);

    assert_enter_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b_o) |-> $past(ready_o) && $past(ph0_o) && hold_n_o);

    assert_bus_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req_n_o |-> phase_b_o && ph1_o);

    assert_lock_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_b_o) |-> lockout_o);

    assert_stat_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phase_a_o) |-> !stat_o);

    assert_req_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_clr_i || sw_touch_i || ctl_touch_i) |=> &req_pend_o);

endmodule

bind psw_switch_seq psw_seq_checks #(.REQ_N(REQ_N)) u_seq_checks (
    .clk         (clk),
    .rst_n       (rst_n),
    .addr_clr_i  (addr_clr_i),
    .sw_touch_i  (sw_touch_i),
    .ctl_touch_i (ctl_touch_i),
    .ph0_o       (ph0_o),
    .ph1_o       (ph1_o),
    .oneshot_o   (oneshot_o),
    .armed_o     (armed_o),
    .phase_a_o   (phase_a_o),
    .hold_n_o    (hold_n_o),
    .ready_o     (ready_o),
    .phase_b_o   (phase_b_o),
    .bus_req_n_o (bus_req_n_o),
    .lockout_o   (lockout_o),
    .stat_o      (stat_o),
    .req_pend_o  (req_pend_o)
);

// File: tb/tb_psw_switch_seq.sv
module tb_psw_switch_seq;
    localparam int DLY = 40;
    localparam int PUL = 5;
    localparam int HLD = 30;
    localparam int RQ  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic halt = 1'b0, stat_set = 1'b0, addr_clr = 1'b0, sw_touch = 1'b0, ctl_touch = 1'b0;
    logic [RQ-1:0] ack = '0;

    logic ph0, ph1, slow_n, oneshot, armed, pha, pha_n, hold_n, ready, phb, phb_n, busreq_n, lockout, stat;
    logic [RQ-1:0] pend;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    psw_switch_seq #(.DELAY_CYC(DLY), .PULSE_CYC(PUL), .HOLD_CYC(HLD), .REQ_N(RQ)) dut (
        .clk(clk), .rst_n(rst_n), .halt_sw_i(halt), .stat_set_i(stat_set),
        .addr_clr_i(addr_clr), .sw_touch_i(sw_touch), .ctl_touch_i(ctl_touch),
        .req_ack_i(ack), .ph0_o(ph0), .ph1_o(ph1), .slow_clk_n_o(slow_n),
        .oneshot_o(oneshot), .armed_o(armed), .phase_a_o(pha), .phase_a_n_o(pha_n),
        .hold_n_o(hold_n), .ready_o(ready), .phase_b_o(phb), .phase_b_n_o(phb_n),
        .bus_req_n_o(busreq_n), .lockout_o(lockout), .stat_o(stat), .req_pend_o(pend)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // m_st: 0 idle, 1 delay, 2 pulse, 3 armed, 4 A, 5 hold wait, 6 ready, 7 B
    int m_k, m_st, m_tmr, m_hold;
    bit m_lock, m_stat;
    bit [RQ-1:0] m_req;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_k = 0; m_st = 0; m_tmr = 0; m_hold = 0;
            m_lock = 0; m_stat = 0; m_req = '1;
        end else begin
            bit p0, ea, eb;
            int nst;
            p0  = (m_k % 8) == 3;
            ea  = (m_st == 3) && p0;
            eb  = (m_st == 6) && p0;
            nst = m_st;
            case (m_st)
                0: if (halt && !m_lock) begin nst = 1; m_tmr = DLY - 1; end
                1: if (m_tmr == 0) begin nst = 2; m_tmr = PUL - 1; end else m_tmr--;
                2: if (m_tmr == 0) nst = 3; else m_tmr--;
                3: if (p0) nst = 4;
                4: if (p0) nst = 5;
                5: if (m_hold == 0) nst = 6;
                6: if (p0) nst = 7;
                7: if (p0) nst = 0;
                default: nst = 0;
            endcase
            if (ea) m_hold = HLD; else if (m_hold > 0) m_hold--;
            if (eb) m_lock = 1; else if (!halt) m_lock = 0;
            m_stat = ea ? 1'b0 : (m_stat | stat_set);
            for (int i = 0; i < RQ; i++) begin
                if (addr_clr || sw_touch || ctl_touch) m_req[i] = 1'b1;
                else if (ack[i]) m_req[i] = 1'b0;
            end
            m_st = nst;
            m_k++;
        end
    end

    // ---------------- compare every cycle, plus event counters ----------------
    int n_pulse, n_hold, n_bus, n_pa;
    bit pa_prev;

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 ph0", ph0, int'((m_k % 8) == 3));
            chk("R1 ph1", ph1, int'((m_k % 8) == 7));
            chk("R2 slow_n", slow_n, int'(((m_k % 16) / 8) == 0));
            chk("R3 oneshot", oneshot, int'(m_st == 2));
            chk("R4 armed", armed, int'(m_st == 3));
            chk("R4 phase_a", pha, int'(m_st == 4));
            chk("R5 hold_n", hold_n, int'(m_hold == 0));
            chk("R6 ready", ready, int'(m_st == 6));
            chk("R7 phase_b", phb, int'(m_st == 7));
            chk("R7 bus_req_n", busreq_n, int'(!((m_st == 7) && ((m_k % 8) == 7))));
            chk("R8 lockout", lockout, int'(m_lock));
            chk("R9 stat", stat, int'(m_stat));
            chk("R10 req_pend", int'(pend), int'(m_req));
            chk("R12 phase_a_n", pha_n, int'(!pha));
            chk("R12 phase_b_n", phb_n, int'(!phb));
            if (oneshot) n_pulse++;
            if (!hold_n) n_hold++;
            if (!busreq_n) n_bus++;
            if (pha && !pa_prev) n_pa++;
            pa_prev = pha;
        end else begin
            pa_prev = 1'b0;
        end
    end

    task automatic clr_counts();
        n_pulse = 0; n_hold = 0; n_bus = 0; n_pa = 0;
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        clr_counts();
        cyc(3);
        // R11: reset state while rst_n is low
        chk("R11 phase_a", pha, 0);
        chk("R11 phase_b", phb, 0);
        chk("R11 oneshot", oneshot, 0);
        chk("R11 hold_n", hold_n, 1);
        chk("R11 bus_req_n", busreq_n, 1);
        chk("R11 lockout", lockout, 0);
        chk("R11 stat", stat, 0);
        chk("R11 req_pend", int'(pend), 3);
        chk("R11 ph0", ph0, 0);
        chk("R11 slow_n", slow_n, 1);
        rst_n = 1'b1;
        cyc(20);

        // R10: acknowledges and a set/ack collision
        ack = 2'b01; cyc(1); ack = '0; cyc(2);
        chk("R10 ack bit0", int'(pend), 2);
        ack = 2'b10; cyc(1); ack = '0; cyc(2);
        chk("R10 ack bit1", int'(pend), 0);
        addr_clr = 1'b1; ack = 2'b11; cyc(1); addr_clr = 1'b0; ack = '0; cyc(1);
        chk("R10 set wins", int'(pend), 3);
        ack = 2'b11; cyc(1); ack = '0; sw_touch = 1'b1; cyc(1); sw_touch = 1'b0;
        ack = 2'b11; cyc(1); ack = '0; ctl_touch = 1'b1; cyc(1); ctl_touch = 1'b0; cyc(1);
        chk("R10 ctl touch", int'(pend), 3);

        // Scenario A: switch held throughout, status set during delay
        clr_counts();
        halt = 1'b1;
        cyc(10); stat_set = 1'b1; cyc(1); stat_set = 1'b0;
        cyc(300);
        chk("R3 pulse width", n_pulse, PUL);
        chk("R5 hold width", n_hold, HLD);
        chk("R7 bus req count", n_bus, 1);
        chk("R8 single pass while held", n_pa, 1);
        chk("R8 lockout held", lockout, 1);
        chk("R9 stat cleared", stat, 0);
        halt = 1'b0; cyc(2);
        chk("R8 lockout released", lockout, 0);

        // Scenario B: short touch, then a second touch inside the pass
        clr_counts();
        halt = 1'b1; cyc(5); halt = 1'b0;
        cyc(60); halt = 1'b1; cyc(3); halt = 1'b0;
        cyc(300);
        chk("R8 retouch ignored", n_pa, 1);
        chk("R7 bus req count B", n_bus, 1);
        chk("R3 pulse width B", n_pulse, PUL);

        // Scenario C: reset mid-pass with switch held, then a fresh pass
        halt = 1'b1; cyc(70);
        rst_n = 1'b0; cyc(2);
        chk("R11 phase_a mid", pha, 0);
        chk("R11 hold_n mid", hold_n, 1);
        chk("R11 req_pend mid", int'(pend), 3);
        rst_n = 1'b1;
        clr_counts();
        cyc(300);
        chk("R3 restart after reset", n_pa, 1);
        halt = 1'b0; cyc(10);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R3 watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule